// File: doc/BRIEF.md
# Socket Status-Change Event and Mask Logic

This block keeps the status-change state of one card socket. It watches four status inputs that are already synchronised: the card status-change line, the two card-detect lines and the power-cycle indication. When one of these inputs changes, the block latches a sticky event bit. Software clears an event bit by writing one to it. Software can also raise any event bit through a separate force register.

A mask register selects which latched events drive the socket interrupt. The block also returns the sampled input levels through a present-state register, together with a flag that gives the card type. The status-change event depends on the card type. For a 32-bit bus card it is raised only on a rising edge. For a 16-bit card it is raised on either edge.

All registers sit on a simple word-addressed register bus. The bus has a single-cycle write strobe and a combinational read path. Address bits [1:0] are ignored.

Top module: `cb_sock_evt`

## Requirements
- R1: After reset, the event and mask registers read 0 and `sock_irq` is low. Input levels that are present when reset is released raise no event, because the first clock after reset only samples them.
- R2: A change of `pwrcyc` between two consecutive clock samples sets event bit 3 at the second edge.
- R3: A change of `ccd2` between two consecutive samples sets event bit 2, and a change of `ccd1` sets event bit 1.
- R4: When `card16` is 0, a rising edge of `stschg` sets event bit 0 and a falling edge does not.
- R5: When `card16` is 1, either edge of `stschg` sets event bit 0.
- R6: Offset 00h is the event register. Writing 1 to one of its bits [3:0] clears that bit, and writing 0 leaves the bit unchanged.
- R7: Offset 0Ch is the force register. Writing 1 to bit n (n in 0..3) sets event bit n. A read of 0Ch returns 0.
- R8: If a hardware set or a forced set arrives in the same cycle as a write-1 clear of the same bit, the bit ends as 1.
- R9: Offset 04h is the mask. Bits [3:0] are read/write and reset to 0, and bits [31:4] read 0. `sock_irq` is the OR of (event[3:0] AND mask[3:0]). This includes events that were latched before the mask was opened.
- R10: Offset 08h is the present state. Bit 0 is `stschg`, bit 1 is `ccd1`, bit 2 is `ccd2` and bit 3 is `pwrcyc`, all as sampled at the last clock edge. Bit 4 is `card16`, and the other bits read 0.
- R11: Event bits [31:4] read 0. Offsets other than 00h, 04h, 08h and 0Ch read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| stschg | input | 1 | Synchronised card status-change line |
| ccd1 | input | 1 | Synchronised card-detect line 1 |
| ccd2 | input | 1 | Synchronised card-detect line 2 |
| pwrcyc | input | 1 | Synchronised power-cycle status |
| card16 | input | 1 | 1 when a 16-bit card is present, 0 for a 32-bit bus card |
| rdata | output | DATA_W | Read data for `addr` |
| sock_irq | output | 1 | Socket interrupt request |

## Verification
A wrong sampled copy of an input shows up at offset 08h one edge after the input moves. It also raises a spurious event or misses one at the next edge. A stuck event or mask bit changes `sock_irq` in the same cycle that the mask or event makes the bit matter. The bench reads every offset after every kind of write. It compares `rdata` and `sock_irq` against a model each cycle, so any divergence is reported within one cycle of the stimulus.

// File: rtl/cb_sock_evt.sv
module cb_sock_evt #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stschg,
  input  logic              ccd1,
  input  logic              ccd2,
  input  logic              pwrcyc,
  input  logic              card16,
  output logic [DATA_W-1:0] rdata,
  output logic              sock_irq
);
  localparam int NEV    = 4;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_EVT = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_MSK = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_PST = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_FRC = WORD_W'(3);

  logic [WORD_W-1:0] word;
  logic [NEV-1:0]    live, samp_q, evt_q, msk_q, chg, hw_set, clr, frc;
  logic              armed_q;

  wire unused_bits = ^{addr[1:0], wdata[DATA_W-1:NEV]};

  assign word = addr[ADDR_W-1:2];
  assign live = {pwrcyc, ccd2, ccd1, stschg};
  assign chg  = armed_q ? (live ^ samp_q) : '0;

  assign hw_set[NEV-1:1] = chg[NEV-1:1];
  assign hw_set[0] = card16 ? chg[0] : (armed_q & live[0] & ~samp_q[0]);

  assign clr = (wr_en && word == W_EVT) ? wdata[NEV-1:0] : '0;
  assign frc = (wr_en && word == W_FRC) ? wdata[NEV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      armed_q <= 1'b0;
      evt_q   <= '0;
      msk_q   <= '0;
    end else begin
      samp_q  <= live;
      armed_q <= 1'b1;
      evt_q   <= (evt_q & ~clr) | hw_set | frc;
      if (wr_en && word == W_MSK) msk_q <= wdata[NEV-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (word)
      W_EVT:   rdata[NEV-1:0] = evt_q;
      W_MSK:   rdata[NEV-1:0] = msk_q;
      W_PST:   rdata[NEV:0]   = {card16, samp_q};
      default: rdata = '0;
    endcase
  end

  assign sock_irq = |(evt_q & msk_q);
endmodule

// File: rtl/cb_sock_evt_chk.sv
module cb_sock_evt_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              stschg,
  input logic              ccd1,
  input logic              pwrcyc,
  input logic              card16,
  input logic [3:0]        evt,
  input logic [DATA_W-1:0] rdata,
  input logic              sock_irq
);
  logic p_st, p_c1, p_pw, arm;
  logic frc_wr, evt_wr;

  assign frc_wr = wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(3);
  assign evt_wr = wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_st <= 1'b0; p_c1 <= 1'b0; p_pw <= 1'b0; arm <= 1'b0;
    end else begin
      p_st <= stschg; p_c1 <= ccd1; p_pw <= pwrcyc; arm <= 1'b1;
    end
  end

  assert_pwr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm && (pwrcyc != p_pw) |=> evt[3]);

  assert_ccd1_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm && (ccd1 != p_c1) |=> evt[1]);

  assert_cb_fall_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !card16 && p_st && !stschg && !evt[0] && !(frc_wr && wdata[0]) |=> !evt[0]);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr && wdata[1] && !(arm && ccd1 != p_c1) |=> !evt[1]);

  assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frc_wr && wdata[0] |=> evt[0]);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == 4'd0) |-> !sock_irq);

  assert_evt_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:2] == '0) |-> (rdata[DATA_W-1:4] == '0));
endmodule

bind cb_sock_evt cb_sock_evt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .stschg(stschg), .ccd1(ccd1), .pwrcyc(pwrcyc), .card16(card16),
  .evt(evt_q), .rdata(rdata), .sock_irq(sock_irq)
);

// File: tb/sim_cb_sock_evt.sv
`timescale 1ns/1ps
module sim_cb_sock_evt;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, seen;
  logic        stschg = 1'b0, ccd1 = 1'b0, ccd2 = 1'b0, pwrcyc = 1'b0, card16 = 1'b0;
  logic        sock_irq;
  logic        st = 1'b1, c1 = 1'b1, c2 = 1'b1, pw = 1'b1, c16 = 1'b0;
  logic [3:0]  m_evt = '0, m_msk = '0, m_prev = '0;
  logic        m_arm = 1'b0;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  cb_sock_evt u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stschg(stschg), .ccd1(ccd1), .ccd2(ccd2), .pwrcyc(pwrcyc), .card16(card16),
    .rdata(rdata), .sock_irq(sock_irq));

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a[7:2])
      6'd0: return {28'd0, m_evt};
      6'd1: return {28'd0, m_msk};
      6'd2: return {27'd0, c16, m_prev};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input logic w, input logic [7:0] a, input logic [31:0] d, input string req);
    logic [3:0] live, chg, set, clr, frc;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    stschg = st; ccd1 = c1; ccd2 = c2; pwrcyc = pw; card16 = c16;
    #1;
    seen = rdata;
    chk(req, rdata, exp_read(a));
    chk({req, " irq"}, {31'd0, sock_irq}, {31'd0, |(m_evt & m_msk)});
    live = {pw, c2, c1, st};
    chg  = m_arm ? (live ^ m_prev) : 4'd0;
    set  = {chg[3:1], c16 ? chg[0] : (m_arm & live[0] & ~m_prev[0])};
    clr  = (w && a[7:2] == 6'd0) ? d[3:0] : 4'd0;
    frc  = (w && a[7:2] == 6'd3) ? d[3:0] : 4'd0;
    m_evt = (m_evt & ~clr) | set | frc;
    if (w && a[7:2] == 6'd1) m_msk = d[3:0];
    m_prev = live;
    m_arm  = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    stschg = 1; ccd1 = 1; ccd2 = 1; pwrcyc = 1;
    #5;
    chk("R1 evt", rdata, 32'd0);
    chk("R1 irq", {31'd0, sock_irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    tick(0, 8'h00, 0, "R1"); tick(0, 8'h00, 0, "R1");
    chk("R1 no event from levels", seen, 32'd0);
    tick(0, 8'h04, 0, "R1"); chk("R1 mask", seen, 32'd0);
    tick(0, 8'h08, 0, "R10"); chk("R10 present", seen, 32'h0F);
    st = 0; tick(0, 8'h00, 0, "R4"); tick(0, 8'h00, 0, "R4");
    chk("R4 falling ignored", seen, 32'd0);
    st = 1; tick(0, 8'h00, 0, "R4"); tick(0, 8'h00, 0, "R4");
    chk("R4 rising sets", seen, 32'd1);
    tick(1, 8'h00, 32'hFFFF_FFF0, "R6"); tick(0, 8'h00, 0, "R6");
    chk("R6 write zero keeps", seen, 32'd1);
    tick(1, 8'h00, 32'h1, "R6"); tick(0, 8'h00, 0, "R6");
    chk("R6 write one clears", seen, 32'd0);
    c16 = 1; st = 0; tick(0, 8'h00, 0, "R5"); tick(0, 8'h00, 0, "R5");
    chk("R5 falling sets", seen, 32'd1);
    c1 = 0; tick(0, 8'h00, 0, "R3"); tick(0, 8'h00, 0, "R3");
    chk("R3 ccd1", seen, 32'd3);
    pw = 0; tick(0, 8'h00, 0, "R2"); tick(0, 8'h00, 0, "R2");
    chk("R2 power cycle", seen, 32'hB);
    tick(0, 8'h08, 0, "R10"); chk("R10 present 16-bit", seen, 32'h14);
    c2 = 0; tick(1, 8'h00, 32'hF, "R8"); tick(0, 8'h00, 0, "R8");
    chk("R8 set wins", seen, 32'h4);
    tick(1, 8'h0C, 32'h9, "R7"); tick(0, 8'h0C, 0, "R7");
    chk("R7 force reads zero", seen, 32'd0);
    tick(0, 8'h00, 0, "R7"); chk("R7 forced bits", seen, 32'hD);
    chk("R9 masked irq", {31'd0, sock_irq}, 32'd0);
    tick(1, 8'h04, 32'hFFFF_FFFF, "R9"); tick(0, 8'h04, 0, "R9");
    chk("R9 mask readback", seen, 32'hF);
    chk("R9 pending irq", {31'd0, sock_irq}, 32'd1);
    tick(1, 8'h14, 32'hFFFF_FFFF, "R11"); tick(1, 8'h10, 32'hFFFF_FFFF, "R11");
    tick(0, 8'h14, 0, "R11"); chk("R11 unmapped", seen, 32'd0);
    tick(0, 8'h04, 0, "R11"); chk("R11 mask untouched", seen, 32'hF);
    tick(1, 8'h00, 32'hFFFF_FFFF, "R9"); tick(0, 8'h00, 0, "R9");
    chk("R9 cleared", seen, 32'd0);
    chk("R9 irq drops", {31'd0, sock_irq}, 32'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      string tg;
      if (($urandom % 8) == 0) st = ~st;
      if (($urandom % 12) == 0) c1 = ~c1;
      if (($urandom % 12) == 0) c2 = ~c2;
      if (($urandom % 16) == 0) pw = ~pw;
      if (($urandom % 200) == 0) c16 = ~c16;
      a = {3'($urandom % 8), 5'd0} >> 3 << 2;
      case (a[7:2])
        6'd0: tg = "R6 random";
        6'd1: tg = "R9 random";
        6'd2: tg = "R10 random";
        6'd3: tg = "R7 random";
        default: tg = "R11 random";
      endcase
      tick(($urandom % 3) == 0, a, $urandom, tg);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule